// File: doc/BRIEF.md
# Shutter exposure timer

This block keeps a camera shutter open for a fixed number of clock cycles after a one-cycle start pulse. A supervising controller raises the start pulse for one cycle and applies a small select code. The block then raises a registered exposure level exactly one cycle later. It holds that level for the number of cycles that a constant table assigns to the select code. When the count runs out, the level drops without any further command.

The select code is captured when the start pulse is accepted. The supervisor can therefore change it freely during an exposure without affecting the exposure already running. A start pulse that arrives while the shutter is open is discarded. Because the latency and the length are both fixed, the supervisor can predict the exact cycle in which the shutter opens and the exact cycle in which it closes.

Top module: `shutter_timer`

## Requirements
- R1: While `rst` is high, `shutterOpen` is low and pulses on `startPulse` have no effect; after `rst` falls, `shutterOpen` stays low until a start pulse is accepted.
- R2: A start pulse sampled at a rising clock edge while `shutterOpen` is low drives `shutterOpen` high from that edge onward. The level is seen in the cycle after the pulse, never in the same cycle.
- R3: Once high, `shutterOpen` stays high for exactly `DUR_TABLE[lenSel]` clock cycles, where `lenSel` is the value sampled together with the accepted pulse. The default table maps code 0 to 3, code 1 to 10, code 2 to 20 and code 3 to 40 cycles.
- R4: `shutterOpen` returns low by itself at the end of the exposure, with no input activity required.
- R5: A change of `lenSel` during an exposure does not alter that exposure's length.
- R6: A start pulse sampled while `shutterOpen` is high is discarded: it neither stretches nor restarts the exposure, and it does not cause a later exposure.
- R7: A start pulse sampled in the first cycle after `shutterOpen` falls is accepted normally, with the R2 latency and the R3 length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| startPulse | input | 1 | One-cycle request to begin an exposure |
| lenSel | input | SEL_W (2) | Index into the exposure length table |
| shutterOpen | output | 1 | Registered exposure window, high while the shutter is open |

## Verification
The checker tracks properties that apply on every cycle. It confirms that the output is low during reset and that every accepted pulse raises the level on the next edge. It confirms that every rise traces back to a pulse sampled while idle. It also checks that each high run has exactly the table length captured at acceptance. The scenarios in the bench demonstrate the behaviours that depend on a chosen stimulus: a select change in mid-exposure, a pulse that lands inside a running exposure, and a pulse in the first idle cycle after an exposure ends.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

  // Command strobes from the control FSM to the counter datapath.
  typedef struct packed {
    logic load;   // capture the selected length into the counter
    logic step;   // count down one cycle of the running exposure
  } shutter_cmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } shutter_state_e;

endpackage

// File: rtl/shutter_dpath.sv
module shutter_dpath
  import shutter_pkg::*;
#(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned NUM_SEL = 4,
  parameter int unsigned DUR_TABLE [NUM_SEL] = '{3, 10, 20, 40},
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  shutter_cmd_t     cmd,
  input  logic [SEL_W-1:0] lenSel,
  output logic             cntZero
);

  logic [CNT_W-1:0] loadVal [NUM_SEL];
  logic [CNT_W-1:0] remain;

  // Remaining-cycle preload for every table entry.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_load
    assign loadVal[g] = CNT_W'(DUR_TABLE[g] - 1);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      remain <= '0;
    end else if (cmd.load) begin
      remain <= loadVal[lenSel];
    end else if (cmd.step && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign cntZero = (remain == '0);

endmodule

// File: rtl/shutter_ctrl.sv
module shutter_ctrl
  import shutter_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         startPulse,
  input  logic         cntZero,
  output shutter_cmd_t cmd,
  output logic         shutterOpen
);

  shutter_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          cmd.load  = 1'b1;
          stateNext = ST_OPEN;
        end
      end
      ST_OPEN: begin
        cmd.step = 1'b1;
        if (cntZero) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // Moore output straight from the state register: glitch free.
  assign shutterOpen = (state == ST_OPEN);

endmodule

// File: rtl/shutter_timer.sv
module shutter_timer #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned DUR_TABLE [2**SEL_W] = '{3, 10, 20, 40}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startPulse,
  input  logic [SEL_W-1:0] lenSel,
  output logic             shutterOpen
);
  import shutter_pkg::*;

  localparam int unsigned NUM_SEL = 2**SEL_W;

  function automatic int unsigned longestDur();
    int unsigned m = 1;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (DUR_TABLE[i] > m) m = DUR_TABLE[i];
    end
    return m;
  endfunction

  localparam int unsigned CNT_W = $clog2(longestDur() + 1);

  shutter_cmd_t cmd;
  logic         cntZero;

  shutter_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .cntZero    (cntZero),
    .cmd        (cmd),
    .shutterOpen(shutterOpen)
  );

  shutter_dpath #(
    .SEL_W    (SEL_W),
    .NUM_SEL  (NUM_SEL),
    .DUR_TABLE(DUR_TABLE),
    .CNT_W    (CNT_W)
  ) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .lenSel (lenSel),
    .cntZero(cntZero)
  );

endmodule

// File: rtl/shutter_timer_chk.sv
module shutter_timer_chk #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned DUR_TABLE [2**SEL_W] = '{3, 10, 20, 40}
) (
  input logic             clk,
  input logic             rst,
  input logic             startPulse,
  input logic [SEL_W-1:0] lenSel,
  input logic             shutterOpen
);

  int unsigned runLen;
  int unsigned expLen;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      runLen <= 0;
      expLen <= 0;
    end else begin
      runLen <= shutterOpen ? runLen + 1 : 0;
      if (startPulse && !shutterOpen) expLen <= DUR_TABLE[lenSel];
    end
  end

  a_r1_low_in_reset: assert property (@(posedge clk) rst |-> !shutterOpen);

  a_r2_open_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (startPulse && !shutterOpen) |=> shutterOpen);

  a_r2_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(shutterOpen) |-> $past(startPulse));

  a_r3_run_length: assert property (@(posedge clk) disable iff (rst)
    $fell(shutterOpen) |-> (runLen == expLen));

  a_r6_no_stretch: assert property (@(posedge clk) disable iff (rst)
    shutterOpen |-> (runLen < expLen));

endmodule

bind shutter_timer shutter_timer_chk #(
  .SEL_W    (SEL_W),
  .DUR_TABLE(DUR_TABLE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .startPulse (startPulse),
  .lenSel     (lenSel),
  .shutterOpen(shutterOpen)
);

// File: tb/shutter_timer_bench.sv
`timescale 1ns/1ps
module shutter_timer_bench;

  localparam int unsigned SEL_W = 2;
  localparam int unsigned DUR [4] = '{3, 10, 20, 40};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             startPulse = 1'b0;
  logic [SEL_W-1:0] lenSel = '0;
  logic             shutterOpen;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  typedef struct {
    int    len;
    int    riseCyc;
    string tag;
  } exp_item_t;

  exp_item_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shutter_timer #(.SEL_W(SEL_W), .DUR_TABLE(DUR)) u_shutter_timer (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .lenSel     (lenSel),
    .shutterOpen(shutterOpen)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Driver: called at a falling edge, issues an accepted pulse.
  task automatic fire(input int sel, input string tag);
    exp_item_t it;
    lenSel     = SEL_W'(sel);
    startPulse = 1'b1;
    it.len     = int'(DUR[sel]);
    it.riseCyc = cyc + 1;
    it.tag     = tag;
    expQ.push_back(it);
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // Driver: pulse that must be discarded (nothing queued).
  task automatic strayPulse(input int sel);
    lenSel     = SEL_W'(sel);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (shutterOpen);
  endtask

  // Monitor: compares rise cycle and high-run length against the queue.
  bit prevOpen = 1'b0;
  int riseAt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (shutterOpen && !prevOpen) begin
        riseAt = cyc;
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected exposure", 1, 0);
        end else begin
          check(cyc == expQ[0].riseCyc, {"R2 latency ", expQ[0].tag}, cyc, expQ[0].riseCyc);
        end
      end
      if (!shutterOpen && prevOpen && expQ.size() != 0) begin
        check(cyc - riseAt == expQ[0].len, {"R3/R4 length ", expQ[0].tag},
              cyc - riseAt, expQ[0].len);
        void'(expQ.pop_front());
      end
    end
    prevOpen = shutterOpen;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: pulses during reset are ignored, output low
    @(negedge clk);
    check(shutterOpen == 1'b0, "R1 reset state", shutterOpen, 0);
    strayPulse(1);
    @(negedge clk);
    check(shutterOpen == 1'b0, "R1 pulse in reset", shutterOpen, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(shutterOpen == 1'b0, "R1 idle after reset", shutterOpen, 0);

    // R3: each table entry
    for (int s = 0; s < 4; s++) begin
      fire(s, "R3");
      waitIdle();
      repeat (2) @(negedge clk);
    end

    // R5: select changes during exposure
    fire(1, "R5");
    lenSel = 2'd3;
    repeat (4) @(negedge clk);
    lenSel = 2'd0;
    waitIdle();
    @(negedge clk);

    // R6: pulses inside a running exposure are discarded
    fire(2, "R6");
    repeat (5) @(negedge clk);
    strayPulse(3);
    repeat (6) @(negedge clk);
    strayPulse(0);
    waitIdle();
    repeat (8) @(negedge clk);
    check(shutterOpen == 1'b0, "R6 no late exposure", shutterOpen, 0);

    // R6: pulse in the final open cycle is also discarded
    fire(0, "R6 last");
    @(negedge clk);
    @(negedge clk);
    strayPulse(1);
    repeat (4) @(negedge clk);
    check(shutterOpen == 1'b0, "R6 last-cycle pulse", shutterOpen, 0);

    // R7: back-to-back exposure in first idle cycle
    fire(0, "R7 first");
    waitIdle();
    fire(1, "R7 second");
    waitIdle();
    repeat (3) @(negedge clk);

    check(expQ.size() == 0, "R4 all exposures ended", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule